// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block is the DMA-side sequencer of an Ethernet transmit path. Software builds a ring of 16-byte descriptors in memory, programs the ring base, hands descriptors to the controller by setting an ownership bit, and then kicks the engine with a poll-demand write. The engine walks the ring from its current slot. For each owned descriptor it reads the control word and the buffer pointer, asks the downstream transmitter to move that buffer, waits for the transmit result, writes the outcome back into the descriptor, clears ownership and steps to the next slot. A descriptor that software still owns ends the pass.

The block sees memory through a word-wide request/acknowledge port, sees software through a two-entry register write port, and sees the transmitter through a request/accept handshake followed by a completion strobe that carries the collision result. Events come out as single-cycle interrupt pulses at fixed bit positions of an interrupt vector.

Top module: `txring_fetch`

## Requirements
- R1: After reset no memory request, no transmit request and no interrupt pulse is raised, and the ring pointer sits at byte address 0.
- R2: A register write with `reg_sel`=1 (poll demand), whatever its data, starts a pass whose first access is a read of word 0 (byte offset 0) of the slot at the ring pointer.
- R3: When bit 31 of word 0 is set, the engine reads word 1 (offset 4) and word 2 (offset 8), then raises `tx_req` with `tx_addr` = word 2, `tx_len` = word 1 bits 10:0, `tx_first` = word 1 bit 28 and `tx_last` = word 1 bit 27; other word 1 bits do not reach the request.
- R4: When bit 31 of word 0 is clear, the engine pulses `irq` bit 3, issues no transmit request, ends the pass and leaves the pointer on that same slot.
- R5: After a descriptor is finished the next slot is the current one plus 16 bytes, or the ring base when bit 31 of word 1 (end of ring) was set; the pass then continues without another poll.
- R6: Acceptance of `tx_req` by `tx_ack` pulses `irq` bit 2 one cycle later.
- R7: On completion the engine writes word 0 of the same slot with bit 31 clear, bit 0 = late-collision abort, bit 1 = excess-collision abort and all other bits zero, and that write is acknowledged before any read of the next slot.
- R8: `irq` bit 4 pulses for a descriptor only when its completion reported success, and only after its status write is acknowledged.
- R9: A register write with `reg_sel`=0 loads the ring base from `reg_wdata` with its low four bits forced to zero and moves the pointer there; during a pass the descriptor in flight still writes back to its own slot and the next fetch comes from the new base.
- R10: A poll demand that arrives during a pass is remembered, and a fresh pass starts from the current pointer after the running one ends.
- R11: `mem_req` with its address, write flag and data, and `tx_req` with its address and length, hold steady until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = ring base, 1 = poll demand |
| reg_wdata | input | AW | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data (status word) |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| tx_req | output | 1 | Buffer transmit request |
| tx_addr | output | AW | Buffer byte address |
| tx_len | output | 11 | Buffer length in bytes |
| tx_first | output | 1 | First-segment flag |
| tx_last | output | 1 | Last-segment flag |
| tx_ack | input | 1 | Request accepted, data moved to the FIFO |
| tx_done | input | 1 | Transmit result strobe |
| tx_ok | input | 1 | Result: sent |
| tx_late_col | input | 1 | Result: late-collision abort |
| tx_excess_col | input | 1 | Result: too many collisions |
| irq | output | 5 | Event pulses: bit 2 moved, bit 3 no buffer, bit 4 sent |

## Verification
The bench sweeps the end-of-ring position over every slot of a four-entry ring and checks the full access order, so an engine that wrapped one slot early or late, or that read the next descriptor before its status write landed, shows a wrong address in the memory log. Result codes are rotated across descriptors so a swapped late/excess bit or a status word that kept the ownership bit is caught in memory. A poll arriving mid-pass and a base rewrite mid-pass are both driven: an engine that dropped the poll reads the stalled slot once instead of twice, and one that let the old descriptor advance the pointer after a rebase fetches the slot after the old one.

// File: rtl/txring_pkg.sv
package txring_pkg;

    localparam int WORD_W    = 32;
    localparam int SLOT_B    = 16;
    localparam int OFF_W0    = 0;
    localparam int OFF_W1    = 4;
    localparam int OFF_W2    = 8;
    localparam int ALIGN_LSB = 4;

    localparam int OWN_BIT   = 31;
    localparam int LEN_W     = 11;
    localparam int LAST_BIT  = 27;
    localparam int FIRST_BIT = 28;
    localparam int EOR_BIT   = 31;
    localparam int LATE_BIT  = 0;
    localparam int EXC_BIT   = 1;

    localparam int IRQ_W     = 5;
    localparam int IRQ_MOVED = 2;
    localparam int IRQ_NOBUF = 3;
    localparam int IRQ_SENT  = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD0,
        S_RD1,
        S_RD2,
        S_XREQ,
        S_XWAIT,
        S_WB,
        S_STEP
    } seq_state_e;

    typedef struct packed {
        logic             eor;
        logic             first;
        logic             last;
        logic [LEN_W-1:0] len;
    } ctl_t;

    typedef struct packed {
        logic ok;
        logic late;
        logic exc;
    } result_t;

    function automatic ctl_t decode_ctl(input logic [WORD_W-1:0] w);
        ctl_t c;
        c.eor   = w[EOR_BIT];
        c.first = w[FIRST_BIT];
        c.last  = w[LAST_BIT];
        c.len   = w[LEN_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input result_t r);
        logic [WORD_W-1:0] s;
        s           = '0;
        s[LATE_BIT] = r.late;
        s[EXC_BIT]  = r.exc;
        return s;
    endfunction

endpackage

// File: rtl/txring_ptr.sv
module txring_ptr
    import txring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          base_we,
    input  logic [AW-1:0] base_val,
    input  logic          grab,
    input  logic          adv,
    input  logic          wrap,
    input  logic [AW-1:0] from_addr,
    output logic [AW-1:0] cur_ptr
);
    localparam logic [AW-1:0] STEP_B = AW'(SLOT_B);

    logic [AW-1:0] ring_base;
    logic          rebased;
    logic [AW-1:0] aligned;

    assign aligned = {base_val[AW-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_base <= '0;
            cur_ptr   <= '0;
            rebased   <= 1'b0;
        end else begin
            if (base_we) begin
                ring_base <= aligned;
                cur_ptr   <= aligned;
            end else if (adv && !rebased) begin
                cur_ptr <= wrap ? ring_base : from_addr + STEP_B;
            end
            if (base_we)
                rebased <= 1'b1;
            else if (grab)
                rebased <= 1'b0;
        end
    end

endmodule

// File: rtl/txring_seq.sv
module txring_seq
    import txring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              poll_we,
    input  logic [AW-1:0]     cur_ptr,
    output logic              grab,
    output logic              adv,
    output logic              wrap,
    output logic [AW-1:0]     desc_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              tx_req,
    output logic [AW-1:0]     tx_addr,
    output logic [LEN_W-1:0]  tx_len,
    output logic              tx_first,
    output logic              tx_last,
    input  logic              tx_ack,
    input  logic              tx_done,
    input  logic              tx_ok,
    input  logic              tx_late_col,
    input  logic              tx_excess_col,
    output logic              ev_moved,
    output logic              ev_nobuf,
    output logic              ev_sent
);
    seq_state_e    st;
    logic          pend;
    ctl_t          ctl;
    logic [AW-1:0] buf_addr;
    result_t       res;
    logic [AW-1:0] off;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            pend      <= 1'b0;
            desc_addr <= '0;
            ctl       <= '0;
            buf_addr  <= '0;
            res       <= '0;
        end else begin
            if (poll_we)
                pend <= 1'b1;
            else if (st == S_IDLE && pend)
                pend <= 1'b0;

            unique case (st)
                S_IDLE: begin
                    if (pend) begin
                        desc_addr <= cur_ptr;
                        st        <= S_RD0;
                    end
                end
                S_STEP: begin
                    desc_addr <= cur_ptr;
                    st        <= S_RD0;
                end
                S_RD0: begin
                    if (mem_ack)
                        st <= mem_rdata[OWN_BIT] ? S_RD1 : S_IDLE;
                end
                S_RD1: begin
                    if (mem_ack) begin
                        ctl <= decode_ctl(mem_rdata);
                        st  <= S_RD2;
                    end
                end
                S_RD2: begin
                    if (mem_ack) begin
                        buf_addr <= mem_rdata[AW-1:0];
                        st       <= S_XREQ;
                    end
                end
                S_XREQ: begin
                    if (tx_ack)
                        st <= S_XWAIT;
                end
                S_XWAIT: begin
                    if (tx_done) begin
                        res.ok   <= tx_ok;
                        res.late <= tx_late_col;
                        res.exc  <= tx_excess_col;
                        st       <= S_WB;
                    end
                end
                S_WB: begin
                    if (mem_ack)
                        st <= S_STEP;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            S_RD1:   off = AW'(OFF_W1);
            S_RD2:   off = AW'(OFF_W2);
            default: off = AW'(OFF_W0);
        endcase
    end

    assign mem_req   = (st == S_RD0) || (st == S_RD1) || (st == S_RD2) || (st == S_WB);
    assign mem_we    = (st == S_WB);
    assign mem_addr  = desc_addr + off;
    assign mem_wdata = status_word(res);

    assign tx_req    = (st == S_XREQ);
    assign tx_addr   = buf_addr;
    assign tx_len    = ctl.len;
    assign tx_first  = ctl.first;
    assign tx_last   = ctl.last;

    assign grab      = (st == S_STEP) || (st == S_IDLE && pend);
    assign adv       = (st == S_WB) && mem_ack;
    assign wrap      = ctl.eor;

    assign ev_moved  = (st == S_XREQ) && tx_ack;
    assign ev_nobuf  = (st == S_RD0) && mem_ack && !mem_rdata[OWN_BIT];
    assign ev_sent   = adv && res.ok;

endmodule

// File: rtl/txring_evt.sv
module txring_evt
    import txring_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_moved,
    input  logic             ev_nobuf,
    input  logic             ev_sent,
    output logic [IRQ_W-1:0] irq
);
    logic [IRQ_W-1:0] ev_vec;

    always_comb begin
        ev_vec            = '0;
        ev_vec[IRQ_MOVED] = ev_moved;
        ev_vec[IRQ_NOBUF] = ev_nobuf;
        ev_vec[IRQ_SENT]  = ev_sent;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq <= '0;
        else
            irq <= ev_vec;
    end

endmodule

// File: rtl/txring_fetch.sv
module txring_fetch
    import txring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [AW-1:0]     reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              tx_req,
    output logic [AW-1:0]     tx_addr,
    output logic [LEN_W-1:0]  tx_len,
    output logic              tx_first,
    output logic              tx_last,
    input  logic              tx_ack,
    input  logic              tx_done,
    input  logic              tx_ok,
    input  logic              tx_late_col,
    input  logic              tx_excess_col,
    output logic [IRQ_W-1:0]  irq
);
    logic          base_we;
    logic          poll_we;
    logic          grab;
    logic          adv;
    logic          wrap;
    logic [AW-1:0] desc_addr;
    logic [AW-1:0] cur_ptr;
    logic          ev_moved;
    logic          ev_nobuf;
    logic          ev_sent;

    assign base_we = reg_wr && !reg_sel;
    assign poll_we = reg_wr && reg_sel;

    txring_ptr #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .base_we   (base_we),
        .base_val  (reg_wdata),
        .grab      (grab),
        .adv       (adv),
        .wrap      (wrap),
        .from_addr (desc_addr),
        .cur_ptr   (cur_ptr)
    );

    txring_seq #(.AW(AW)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .poll_we       (poll_we),
        .cur_ptr       (cur_ptr),
        .grab          (grab),
        .adv           (adv),
        .wrap          (wrap),
        .desc_addr     (desc_addr),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ack       (mem_ack),
        .tx_req        (tx_req),
        .tx_addr       (tx_addr),
        .tx_len        (tx_len),
        .tx_first      (tx_first),
        .tx_last       (tx_last),
        .tx_ack        (tx_ack),
        .tx_done       (tx_done),
        .tx_ok         (tx_ok),
        .tx_late_col   (tx_late_col),
        .tx_excess_col (tx_excess_col),
        .ev_moved      (ev_moved),
        .ev_nobuf      (ev_nobuf),
        .ev_sent       (ev_sent)
    );

    txring_evt u_evt (
        .clk      (clk),
        .rst      (rst),
        .ev_moved (ev_moved),
        .ev_nobuf (ev_nobuf),
        .ev_sent  (ev_sent),
        .irq      (irq)
    );

endmodule

// File: rtl/txring_fetch_chk.sv
module txring_fetch_chk
    import txring_pkg::*;
#(
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              tx_req,
    input logic [AW-1:0]     tx_addr,
    input logic [LEN_W-1:0]  tx_len,
    input logic              tx_ack,
    input logic [IRQ_W-1:0]  irq
);

    // R1: a reset cycle leaves the block quiet
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!mem_req && !tx_req && irq == '0));

    // R11: memory request held until acknowledged
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11: transmit request held until accepted
    a_r11_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_ack) |=> (tx_req && $stable(tx_addr) && $stable(tx_len)));

    // R7: status write releases ownership and carries only the two abort bits
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata[WORD_W-1:EXC_BIT+1] == '0));

    // R7: status write targets word 0 of a slot
    a_r7_word0: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr[ALIGN_LSB-1:0] == '0));

    // R6: acceptance pulses the moved bit next cycle
    a_r6_moved: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_ack) |=> irq[IRQ_MOVED]);

    // R8: sent pulse follows an acknowledged status write
    a_r8_sent_after_wb: assert property (@(posedge clk) disable iff (rst)
        irq[IRQ_SENT] |-> $past(mem_req && mem_we && mem_ack));

    // R4: no-buffer pulse never coexists with a transmit request
    a_r4_nobuf_idle: assert property (@(posedge clk) disable iff (rst)
        irq[IRQ_NOBUF] |-> !tx_req);

    // R6/R8/R4: event pulses never overlap
    a_r8_single_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq));

endmodule

bind txring_fetch txring_fetch_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .tx_req    (tx_req),
    .tx_addr   (tx_addr),
    .tx_len    (tx_len),
    .tx_ack    (tx_ack),
    .irq       (irq)
);

// File: tb/sim_txring_fetch.sv
module sim_txring_fetch;
    localparam int CLK_NS = 10;
    localparam int AW     = 32;

    logic clk = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [AW-1:0] reg_wdata = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata;
    logic          mem_ack;
    logic          tx_req;
    logic [AW-1:0] tx_addr;
    logic [10:0]   tx_len;
    logic          tx_first, tx_last;
    logic          tx_ack, tx_done, tx_ok, tx_late_col, tx_excess_col;
    logic [4:0]    irq;

    txring_fetch #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len), .tx_first(tx_first), .tx_last(tx_last),
        .tx_ack(tx_ack), .tx_done(tx_done), .tx_ok(tx_ok), .tx_late_col(tx_late_col),
        .tx_excess_col(tx_excess_col), .irq(irq)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: one-cycle acknowledge, bench pokes through bw_*
    logic        bw_en = 1'b0;
    logic [7:0]  bw_idx = '0;
    logic [31:0] bw_dat = '0;
    logic [31:0] mem [0:255];
    int          rdcnt [0:255];
    logic [31:0] op_addr [0:511];
    logic        op_we [0:511];
    int          op_n;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 256; k++) begin
                mem[k]   <= '0;
                rdcnt[k] <= 0;
            end
            mem_ack <= 1'b0;
            op_n    <= 0;
        end else begin
            if (bw_en) mem[bw_idx] <= bw_dat;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[9:2]] <= mem_wdata;
                end else begin
                    mem_rdata <= mem[mem_addr[9:2]];
                    rdcnt[mem_addr[9:2]] <= rdcnt[mem_addr[9:2]] + 1;
                end
                op_addr[op_n] <= mem_addr;
                op_we[op_n]   <= mem_we;
                op_n          <= op_n + 1;
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    // transmitter model: accept after 3 cycles, result 4 cycles later;
    // result code comes from buffer address bits 4 (late) and 5 (excess)
    logic [31:0] tl_addr [0:63];
    logic [10:0] tl_len [0:63];
    logic        tl_first [0:63];
    logic        tl_last [0:63];
    int          tx_n;
    int          ph, cnt;
    logic [31:0] cur_a;

    always @(posedge clk) begin
        tx_ack  <= 1'b0;
        tx_done <= 1'b0;
        if (rst) begin
            ph <= 0; cnt <= 0; tx_n <= 0;
            tx_ok <= 1'b0; tx_late_col <= 1'b0; tx_excess_col <= 1'b0;
        end else begin
            case (ph)
                0: if (tx_req) begin
                    tl_addr[tx_n]  <= tx_addr;
                    tl_len[tx_n]   <= tx_len;
                    tl_first[tx_n] <= tx_first;
                    tl_last[tx_n]  <= tx_last;
                    tx_n  <= tx_n + 1;
                    cur_a <= tx_addr;
                    cnt   <= 2;
                    ph    <= 1;
                end
                1: if (cnt == 0) begin tx_ack <= 1'b1; cnt <= 3; ph <= 2; end
                   else cnt <= cnt - 1;
                default: if (cnt == 0) begin
                    tx_done       <= 1'b1;
                    tx_ok         <= !(cur_a[4] | cur_a[5]);
                    tx_late_col   <= cur_a[4];
                    tx_excess_col <= cur_a[5];
                    ph            <= 0;
                end else cnt <= cnt - 1;
            endcase
        end
    end

    int n_moved, n_nobuf, n_sent;
    always @(posedge clk) begin
        if (rst) begin
            n_moved <= 0; n_nobuf <= 0; n_sent <= 0;
        end else begin
            if (irq[2]) n_moved <= n_moved + 1;
            if (irq[3]) n_nobuf <= n_nobuf + 1;
            if (irq[4]) n_sent  <= n_sent + 1;
        end
    end

    task automatic reg_write(input logic sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic poke(input logic [31:0] addr, input logic [31:0] val);
        @(negedge clk);
        bw_en = 1'b1; bw_idx = addr[9:2]; bw_dat = val;
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] a, input bit own, input logic [31:0] bufa,
                            input int len, input bit first, input bit last, input bit eor);
        poke(a,     (own ? 32'h8000_0000 : 32'h0) | 32'h0123_0000);
        poke(a + 4, (32'(eor) << 31) | (32'(first) << 28) | (32'(last) << 27) | 32'h800 | 32'(len));
        poke(a + 8, bufa);
    endtask

    task automatic wait_nobuf(input int target);
        while (n_nobuf < target) @(posedge clk);
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] bufof(input int i, input int code);
        return 32'h4000 + 32'(i) * 32'h100 + (32'(code) << 4);
    endfunction

    function automatic logic [31:0] stat_of(input int code);
        return (code == 1) ? 32'h1 : (code == 2) ? 32'h2 : 32'h0;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int o0, t0, nb0, s0, m0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mem_req", mem_req, 0);
        chk("R1 tx_req", tx_req, 0);
        chk("R1 irq", irq, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 quiet after release", {mem_req, tx_req, irq}, 0);

        // R1/R2/R4: poll right after reset reads byte 0, finds nothing
        o0 = op_n; nb0 = n_nobuf;
        reg_write(1'b1, 32'hDEAD_BEEF);
        wait_nobuf(nb0 + 1);
        chk("R1 R2 first read at pointer 0", {op_we[o0], op_addr[o0]}, 33'h0);
        chk("R4 no request", tx_n, 0);
        o0 = op_n;
        reg_write(1'b1, 32'h0);
        wait_nobuf(nb0 + 2);
        chk("R4 pointer stays on slot", {op_we[o0], op_addr[o0]}, 33'h0);
        chk("R4 one access per empty pass", op_n - o0, 1);

        // Main ring: base 0x107 -> aligned 0x100, four slots, end flag on slot 3
        for (int i = 0; i < 4; i++)
            put_desc(32'h100 + 32'(i) * 16, 1'b1, bufof(i, i % 3), 60 + 37 * i,
                     i[0], i[1], i == 3);
        reg_write(1'b0, 32'h107);
        o0 = op_n; t0 = tx_n; nb0 = n_nobuf; s0 = n_sent; m0 = n_moved;
        reg_write(1'b1, 32'h5A);
        wait_nobuf(nb0 + 1);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a;
            a = 32'h100 + 32'(i) * 16;
            chk("R2 R9 word0 read", {op_we[o0+4*i], op_addr[o0+4*i]}, {1'b0, a});
            chk("R3 word1 read", {op_we[o0+4*i+1], op_addr[o0+4*i+1]}, {1'b0, a + 32'd4});
            chk("R3 word2 read", {op_we[o0+4*i+2], op_addr[o0+4*i+2]}, {1'b0, a + 32'd8});
            chk("R7 status write before next read", {op_we[o0+4*i+3], op_addr[o0+4*i+3]}, {1'b1, a});
            chk("R3 tx_addr", tl_addr[t0+i], bufof(i, i % 3));
            chk("R3 tx_len", tl_len[t0+i], 60 + 37 * i);
            chk("R3 tx_first/last", {tl_first[t0+i], tl_last[t0+i]}, {i[0], i[1]});
            chk("R7 status word", mem[a[9:2]], stat_of(i % 3));
        end
        chk("R5 wrap to base", {op_we[o0+16], op_addr[o0+16]}, 33'h100);
        chk("R6 moved pulses", n_moved - m0, 4);
        chk("R8 sent pulses", n_sent - s0, 2);

        // Sweep end-of-ring position
        for (int e = 0; e < 4; e++) begin
            int oks;
            for (int i = 0; i < 4; i++)
                put_desc(32'h200 + 32'(i) * 16, i <= e, bufof(i, (i + e) % 3), 100 + 9 * i + e,
                         (i + e) % 2 == 1, i == e, i == e);
            reg_write(1'b0, 32'h200);
            o0 = op_n; t0 = tx_n; nb0 = n_nobuf; s0 = n_sent;
            reg_write(1'b1, 32'h1);
            wait_nobuf(nb0 + 1);
            chk("R5 request count", tx_n - t0, e + 1);
            chk("R5 access count", op_n - o0, 4 * (e + 1) + 1);
            chk("R5 wrap read", {op_we[o0+4*(e+1)], op_addr[o0+4*(e+1)]}, 33'h200);
            oks = 0;
            for (int i = 0; i <= e; i++) begin
                chk("R3 sweep tx_addr", tl_addr[t0+i], bufof(i, (i + e) % 3));
                chk("R3 sweep tx_len", tl_len[t0+i], 100 + 9 * i + e);
                chk("R7 sweep status", mem[(32'h200 + 32'(i) * 16) >> 2], stat_of((i + e) % 3));
                if ((i + e) % 3 == 0) oks++;
            end
            chk("R8 sweep sent", n_sent - s0, oks);
        end

        // R10: poll during a pass restarts from the stalled slot
        put_desc(32'h40, 1'b1, bufof(0, 0), 64, 1'b1, 1'b1, 1'b0);
        poke(32'h50, 32'h0);
        reg_write(1'b0, 32'h40);
        t0 = tx_n; nb0 = n_nobuf; m0 = rdcnt[32'h50 >> 2];
        reg_write(1'b1, 32'h0);
        while (!tx_req) @(posedge clk);
        reg_write(1'b1, 32'h0);
        wait_nobuf(nb0 + 2);
        chk("R10 second pass reads stalled slot", rdcnt[32'h50 >> 2] - m0, 2);
        chk("R10 one transmit", tx_n - t0, 1);

        // R9: base rewrite mid-pass
        put_desc(32'h300, 1'b1, bufof(0, 1), 80, 1'b0, 1'b1, 1'b0);
        put_desc(32'h310, 1'b1, bufof(1, 0), 81, 1'b0, 1'b1, 1'b0);
        poke(32'h380, 32'h0);
        reg_write(1'b0, 32'h300);
        t0 = tx_n; nb0 = n_nobuf; m0 = rdcnt[32'h310 >> 2]; s0 = rdcnt[32'h380 >> 2];
        reg_write(1'b1, 32'h0);
        while (!tx_req) @(posedge clk);
        reg_write(1'b0, 32'h380);
        wait_nobuf(nb0 + 1);
        chk("R9 in-flight slot written back", mem[32'h300 >> 2], 32'h1);
        chk("R9 old next slot skipped", rdcnt[32'h310 >> 2] - m0, 0);
        chk("R9 new base fetched", rdcnt[32'h380 >> 2] - s0, 1);
        chk("R9 one transmit", tx_n - t0, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule